// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a linked list of 16-byte transfer descriptors held in system memory and hands each one, decoded, to a data mover. A controller pulses `start` with the address of the first descriptor. The walker reads the four 32-bit words of that descriptor through a simple one-outstanding read port. It decodes the buffer address, the length in 8-byte units, the ordering and direction flags, the end marker and the drive timing mode, and offers the result on a valid/ready output. Once the mover takes it, the walker either finishes or follows the descriptor's embedded link to the next entry.

Each descriptor holds four little-endian words: word 0 is the buffer address, word 1 the length, word 2 a control word, and word 3 the link to the next entry. A descriptor whose end flag is set closes the chain, and its link word is not looked at. A descriptor without the end flag must carry a nonzero, 8-byte aligned link. If it does not, the walk stops with an error and that descriptor is never offered. The first address passes the same test when `start` arrives.

Top module: `sg_chain_walker`

## Requirements
- R1: While reset is held and in the cycle after it, `mem_req_valid`, `desc_valid`, `done`, `error` and `busy` are all low.
- R2: After an accepted start at a valid address A, the walker reads A, A+4, A+8 and A+12 in that order. It has at most one read outstanding, and it holds `mem_req_addr` steady while `mem_req_ready` is low.
- R3: A descriptor is offered only after all four of its words have returned. `desc_valid` rises two cycles after the clock edge that accepts the fourth response, and it never overlaps `mem_req_valid`.
- R4: The outputs are decoded as follows. `desc_buf_addr` is word 0 and `desc_len` is word 1, passed unchanged. In word 2, bit 4 drives `desc_ordered`, bit 5 drives `desc_dir_out` and bit 7 drives `desc_last`. Bits 11:8 of word 2 drive `desc_mode`. All other bits of word 2 have no effect on any output.
- R5: While `desc_valid` is high and `desc_ready` is low, `desc_valid` and every descriptor field stay unchanged.
- R6: When a descriptor without the end flag is accepted, the next read goes to the address in its word 3, whether or not that address directly follows the current descriptor.
- R7: When a descriptor with the end flag is accepted, `done` is high for exactly the next cycle and no further read is issued, even if its word 3 is nonzero.
- R8: If a descriptor lacks the end flag and its word 3 is zero or has any of bits 2:0 set, it is not offered. `error` is high for one cycle, two cycles after the edge that accepts its fourth word, and no further read follows.
- R9: A start whose address is zero or has any of bits 2:0 set makes no read and raises `error` for the single cycle after the start edge.
- R10: `start` is ignored while `busy` is high. The walk in progress keeps its read addresses and descriptors.
- R11: A descriptor whose length is zero is offered like any other, with `desc_len` equal to 0, and the walk then proceeds along its link.
- R12: `busy` is high from the cycle after an accepted valid start up to the cycle in which `done` or `error` is high. It is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk at `first_addr` (taken only when idle) |
| first_addr | input | 32 | Byte address of the first descriptor |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| desc_valid | output | 1 | Decoded descriptor offered |
| desc_ready | input | 1 | Mover takes the descriptor |
| desc_buf_addr | output | 32 | Buffer start address |
| desc_len | output | 32 | Buffer length in 8-byte units |
| desc_ordered | output | 1 | Ordered-transfer flag |
| desc_dir_out | output | 1 | Direction flag: 1 means toward the drive |
| desc_last | output | 1 | Descriptor ends the chain |
| desc_mode | output | 4 | Drive DMA timing mode |
| done | output | 1 | One-cycle pulse: chain finished |
| error | output | 1 | One-cycle pulse: walk stopped on a bad link or start address |
| busy | output | 1 | A walk is in progress |

## Verification
A wrong word index or base address shows up as a wrong `mem_req_addr` on the very next request, and the bench compares that address against its own walk of the memory image. A fault in word capture or decode corrupts the fields in the same cycle that `desc_valid` rises. A wrong state transition makes `desc_valid`, `done`, `error` or `busy` differ from the expected per-cycle values within a cycle or two. The reference model tracks those expected values from the handshakes it drives, so a single cycle of skew is reported at once.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int BYTE_SHIFT = $clog2(WORD_W / 8);
    localparam int MODE_W     = 4;

    // word slots inside one descriptor
    localparam int W_BUF  = 0;
    localparam int W_LEN  = 1;
    localparam int W_CTRL = 2;
    localparam int W_LINK = 3;

    // control word bit positions
    localparam int FLAG_ORD  = 4;
    localparam int FLAG_DIR  = 5;
    localparam int FLAG_END  = 7;
    localparam int MODE_LSB  = 8;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_REQ,
        WS_WAIT,
        WS_CHECK,
        WS_EMIT
    } walk_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] buf_addr;
        logic [WORD_W-1:0] len;
        logic              ordered;
        logic              dir_out;
        logic              last;
        logic [MODE_W-1:0] mode;
        logic [WORD_W-1:0] link;
    } desc_t;

    typedef struct packed {
        walk_st_e          st;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] base;
        logic              done;
        logic              error;
    } walk_ctl_t;

    // a link is usable only when nonzero and aligned to the mask
    function automatic logic ptr_unusable(input logic [WORD_W-1:0] a,
                                          input logic [WORD_W-1:0] mask);
        return (a == '0) || ((a & mask) != '0);
    endfunction
endpackage

// File: rtl/sgw_word_store.sv
module sgw_word_store
    import sgw_pkg::*;
#(
    parameter int N_WORDS = DESC_WORDS,
    parameter int W       = WORD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(N_WORDS)-1:0]   wr_idx,
    input  logic [W-1:0]                 wr_data,
    output logic [N_WORDS-1:0][W-1:0]    words
);
    localparam int SEL_W = $clog2(N_WORDS);

    for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
        logic [W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (wr_en && (wr_idx == SEL_W'(g))) begin
                w_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= '0;
            end else begin
                w_q <= w_d;
            end
        end

        assign words[g] = w_q;
    end
endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
    import sgw_pkg::*;
#(
    parameter int ALIGN_BITS = 3
) (
    input  logic [DESC_WORDS-1:0][WORD_W-1:0] words,
    output desc_t                             desc,
    output logic                              chain_broken
);
    localparam logic [WORD_W-1:0] ALIGN_MASK = WORD_W'((64'd1 << ALIGN_BITS) - 64'd1);

    logic [WORD_W-1:0] ctrl;
    logic              unused_ctrl_bits;

    assign ctrl = words[W_CTRL];

    always_comb begin
        desc.buf_addr = words[W_BUF];
        desc.len      = words[W_LEN];
        desc.ordered  = ctrl[FLAG_ORD];
        desc.dir_out  = ctrl[FLAG_DIR];
        desc.last     = ctrl[FLAG_END];
        desc.mode     = ctrl[MODE_LSB +: MODE_W];
        desc.link     = words[W_LINK];
    end

    // a non-terminal entry must point at a usable successor
    assign chain_broken = !desc.last && ptr_unusable(desc.link, ALIGN_MASK);

    // packet length, reserved byte, upper mode nibble and spare flags are not used
    assign unused_ctrl_bits = ^{ctrl[FLAG_ORD-1:0], ctrl[FLAG_END-1],
                                ctrl[WORD_W-1:MODE_LSB+MODE_W]};
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int ALIGN_BITS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] first_addr,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        desc_valid,
    input  logic        desc_ready,
    output logic [31:0] desc_buf_addr,
    output logic [31:0] desc_len,
    output logic        desc_ordered,
    output logic        desc_dir_out,
    output logic        desc_last,
    output logic [3:0]  desc_mode,
    output logic        done,
    output logic        error,
    output logic        busy
);
    localparam logic [WORD_W-1:0] ALIGN_MASK = WORD_W'((64'd1 << ALIGN_BITS) - 64'd1);
    localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(DESC_WORDS - 1);
    localparam walk_ctl_t CTL_RESET = '{st: WS_IDLE, idx: '0, base: '0,
                                        done: 1'b0, error: 1'b0};

    walk_ctl_t                         ctl_d, ctl_q;
    logic                              store_en;
    logic [DESC_WORDS-1:0][WORD_W-1:0] words;
    desc_t                             cur;
    logic                              chain_broken;

    sgw_word_store #(
        .N_WORDS (DESC_WORDS),
        .W       (WORD_W)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (ctl_q.idx),
        .wr_data (mem_rsp_data),
        .words   (words)
    );

    sgw_decode #(
        .ALIGN_BITS (ALIGN_BITS)
    ) i_decode (
        .words        (words),
        .desc         (cur),
        .chain_broken (chain_broken)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.error = 1'b0;
        store_en    = 1'b0;
        unique case (ctl_q.st)
            WS_IDLE: begin
                if (start) begin
                    if (ptr_unusable(first_addr, ALIGN_MASK)) begin
                        ctl_d.error = 1'b1;
                    end else begin
                        ctl_d.st   = WS_REQ;
                        ctl_d.base = first_addr;
                        ctl_d.idx  = '0;
                    end
                end
            end
            WS_REQ: begin
                if (mem_req_ready) begin
                    ctl_d.st = WS_WAIT;
                end
            end
            WS_WAIT: begin
                if (mem_rsp_valid) begin
                    store_en = 1'b1;
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.st = WS_CHECK;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                        ctl_d.st  = WS_REQ;
                    end
                end
            end
            WS_CHECK: begin
                if (chain_broken) begin
                    ctl_d.error = 1'b1;
                    ctl_d.st    = WS_IDLE;
                end else begin
                    ctl_d.st = WS_EMIT;
                end
            end
            WS_EMIT: begin
                if (desc_ready) begin
                    if (cur.last) begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = WS_IDLE;
                    end else begin
                        ctl_d.base = cur.link;
                        ctl_d.idx  = '0;
                        ctl_d.st   = WS_REQ;
                    end
                end
            end
            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req_valid = (ctl_q.st == WS_REQ);
    assign mem_req_addr  = ctl_q.base + (WORD_W'(ctl_q.idx) << BYTE_SHIFT);
    assign desc_valid    = (ctl_q.st == WS_EMIT);
    assign desc_buf_addr = cur.buf_addr;
    assign desc_len      = cur.len;
    assign desc_ordered  = cur.ordered;
    assign desc_dir_out  = cur.dir_out;
    assign desc_last     = cur.last;
    assign desc_mode     = cur.mode;
    assign done          = ctl_q.done;
    assign error         = ctl_q.error;
    assign busy          = (ctl_q.st != WS_IDLE);
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int ALIGN_BITS = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] first_addr,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        desc_valid,
    input logic        desc_ready,
    input logic [31:0] desc_buf_addr,
    input logic [31:0] desc_len,
    input logic        desc_ordered,
    input logic        desc_dir_out,
    input logic        desc_last,
    input logic [3:0]  desc_mode,
    input logic        done,
    input logic        error,
    input logic        busy
);
    localparam logic [31:0] ALIGN_MASK = 32'((64'd1 << ALIGN_BITS) - 64'd1);

    logic start_bad;
    assign start_bad = start && !busy && ((first_addr == '0) || ((first_addr & ALIGN_MASK) != '0));

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_word_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && desc_valid));

    p_desc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid &&
        $stable({desc_buf_addr, desc_len, desc_ordered, desc_dir_out, desc_last, desc_mode}));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(desc_valid && desc_ready && desc_last));

    p_end_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    p_bad_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |=> error && !mem_req_valid);

    p_idle_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !busy);
endmodule

bind sg_chain_walker sgw_checker #(.ALIGN_BITS(ALIGN_BITS)) i_sgw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .first_addr    (first_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .desc_valid    (desc_valid),
    .desc_ready    (desc_ready),
    .desc_buf_addr (desc_buf_addr),
    .desc_len      (desc_len),
    .desc_ordered  (desc_ordered),
    .desc_dir_out  (desc_dir_out),
    .desc_last     (desc_last),
    .desc_mode     (desc_mode),
    .done          (done),
    .error         (error),
    .busy          (busy)
);

// File: tb/test_sg_chain_walker.sv
`timescale 1ns/100ps
module test_sg_chain_walker;
    typedef struct packed {
        logic [31:0] a;
        logic [31:0] l;
        logic        o;
        logic        d;
        logic        e;
        logic [3:0]  m;
    } bdesc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] first_addr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        desc_valid;
    logic        desc_ready = 1'b0;
    logic [31:0] desc_buf_addr;
    logic [31:0] desc_len;
    logic        desc_ordered;
    logic        desc_dir_out;
    logic        desc_last;
    logic [3:0]  desc_mode;
    logic        done;
    logic        error;
    logic        busy;

    always #2.5 clk = ~clk;

    sg_chain_walker i_sg_chain_walker (
        .clk (clk), .rst_n (rst_n), .start (start), .first_addr (first_addr),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data), .desc_valid (desc_valid),
        .desc_ready (desc_ready), .desc_buf_addr (desc_buf_addr),
        .desc_len (desc_len), .desc_ordered (desc_ordered),
        .desc_dir_out (desc_dir_out), .desc_last (desc_last),
        .desc_mode (desc_mode), .done (done), .error (error), .busy (busy)
    );

    int errors = 0;
    int checks = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] q_addr [$];
    bdesc_t      q_desc [$];

    bit exp_dv, exp_done, exp_err, exp_busy;
    bit done_next, err_next, busy_next, hs_prev, bad_pend;
    int cd = 0;
    int pend = -1;
    logic [31:0] pend_addr;
    int wcnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    int rmode = 0;
    bit start_go = 0;
    logic [31:0] start_val;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] b, input logic [31:0] len,
                            input logic [7:0] flags, input logic [7:0] mode,
                            input logic [15:0] hi, input logic [31:0] link);
        mem[at]      = b;
        mem[at + 4]  = len;
        mem[at + 8]  = {hi, mode, flags};
        mem[at + 12] = link;
    endtask

    // behavioural walk of the memory image, from the requirements
    task automatic plan_chain(input logic [31:0] first);
        logic [31:0] a, w2, nx;
        bdesc_t d;
        q_addr.delete();
        q_desc.delete();
        a = first;
        if (a == 0 || a[2:0] != 0) return;
        for (int n = 0; n < 64; n++) begin
            for (int k = 0; k < 4; k++) q_addr.push_back(a + 32'(4 * k));
            w2 = mem[a + 8];
            nx = mem[a + 12];
            d.a = mem[a];
            d.l = mem[a + 4];
            d.o = w2[4];
            d.d = w2[5];
            d.e = w2[7];
            d.m = w2[11:8];
            if (d.e) begin
                q_desc.push_back(d);
                return;
            end
            if (nx == 0 || nx[2:0] != 0) return;
            q_desc.push_back(d);
            a = nx;
        end
    endtask

    function automatic bit rdy_a();
        return (rmode == 0) ? 1'b1 : (lfsr[5] | lfsr[9]);
    endfunction

    function automatic bit rdy_d();
        return (rmode == 0) ? 1'b1 : (lfsr[3] | lfsr[12]);
    endfunction

    task automatic step();
        bdesc_t got;
        logic [31:0] w2b, nxb;
        @(negedge clk);
        exp_done  = done_next; done_next = 0;
        exp_err   = err_next;  err_next  = 0;
        if (busy_next) begin exp_busy = 1; busy_next = 0; end
        if (hs_prev) begin exp_dv = 0; hs_prev = 0; end
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                if (bad_pend) exp_err = 1;
                else exp_dv = 1;
            end
        end
        if (exp_done || exp_err) exp_busy = 0;

        chk(busy === exp_busy, "R12 busy", 32'(busy), 32'(exp_busy));
        chk(done === exp_done, "R7 done pulse", 32'(done), 32'(exp_done));
        chk(error === exp_err, "R8/R9 error pulse", 32'(error), 32'(exp_err));
        chk(desc_valid === exp_dv, "R3 desc_valid timing", 32'(desc_valid), 32'(exp_dv));
        if (desc_valid && exp_dv) begin
            if (q_desc.size() == 0) begin
                chk(0, "R4 unexpected descriptor", desc_buf_addr, 0);
            end else begin
                got = {desc_buf_addr, desc_len, desc_ordered, desc_dir_out, desc_last, desc_mode};
                chk(got.a === q_desc[0].a, "R4 buffer address", got.a, q_desc[0].a);
                chk(got.l === q_desc[0].l, "R4/R11 length", got.l, q_desc[0].l);
                chk({got.o, got.d, got.e} === {q_desc[0].o, q_desc[0].d, q_desc[0].e},
                    "R4 flags", 32'({got.o, got.d, got.e}), 32'({q_desc[0].o, q_desc[0].d, q_desc[0].e}));
                chk(got.m === q_desc[0].m, "R4 mode", 32'(got.m), 32'(q_desc[0].m));
            end
        end
        if (mem_req_valid) begin
            chk(pend < 0, "R2 single outstanding read", 1, 0);
            if (q_addr.size() == 0) chk(0, "R2/R7 unexpected read", mem_req_addr, 0);
            else chk(mem_req_addr === q_addr[0], "R2/R6 read address", mem_req_addr, q_addr[0]);
        end

        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'hDEAD_BEEF;
        if (pend > 0) begin
            pend--;
        end else if (pend == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            pend = -1;
            wcnt++;
            if (wcnt % 4 == 0) begin
                cd  = 2;
                w2b = mem[pend_addr - 4];
                nxb = mem[pend_addr];
                bad_pend = !w2b[7] && (nxb == 0 || nxb[2:0] != 0);
            end
        end

        mem_req_ready = rdy_a();
        if (mem_req_valid && mem_req_ready) begin
            pend = (rmode == 0) ? 0 : int'(lfsr[2:0]) % 3;
            pend_addr = mem_req_addr;
            if (q_addr.size() > 0) q_addr.delete(0);
        end

        desc_ready = rdy_d();
        if (desc_valid && desc_ready) begin
            hs_prev = 1;
            if (q_desc.size() > 0) begin
                if (q_desc[0].e) done_next = 1;
                q_desc.delete(0);
            end
        end

        start = 1'b0;
        if (start_go) begin
            start = 1'b1;
            first_addr = start_val;
            start_go = 0;
            if (!exp_busy && !busy_next) begin
                if (start_val == 0 || start_val[2:0] != 0) err_next = 1;
                else busy_next = 1;
            end
        end
    endtask

    task automatic walk(input logic [31:0] first, input int mode, input int mid_at,
                        input logic [31:0] mid_addr);
        bit fin = 0;
        rmode = mode;
        plan_chain(first);
        wcnt = 0;
        start_go = 1;
        start_val = first;
        for (int c = 0; c < 3000 && !fin; c++) begin
            if (mid_at != 0 && c == mid_at) begin
                start_go = 1;          // R10: must be ignored while busy
                start_val = mid_addr;
            end
            step();
            if (exp_done || exp_err) fin = 1;
        end
        if (!fin) chk(0, "R12 walk finished", 0, 1);
        for (int c = 0; c < 4; c++) step();
        chk(q_addr.size() == 0, "R2/R6 all reads issued", q_addr.size(), 0);
        chk(q_desc.size() == 0, "R4 all descriptors delivered", q_desc.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk({mem_req_valid, desc_valid, done, error, busy} === 5'b0, "R1 outputs in reset",
                32'({mem_req_valid, desc_valid, done, error, busy}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk({mem_req_valid, desc_valid, done, error, busy} === 5'b0, "R1 outputs after reset",
            32'({mem_req_valid, desc_valid, done, error, busy}), 0);

        // contiguous three-entry chain (R2 R3 R4 R6 R7)
        put_desc(32'h1000, 32'hA000_0000, 32'd64, 8'h10, 8'h04, 16'h0000, 32'h1010);
        put_desc(32'h1010, 32'hA000_1000, 32'd32, 8'h30, 8'h04, 16'h0000, 32'h1020);
        put_desc(32'h1020, 32'hA000_2000, 32'd8,  8'hB0, 8'h04, 16'h0000, 32'h0);
        walk(32'h1000, 0, 0, 0);
        walk(32'h1000, 1, 0, 0);

        // zero lengths, ignored bits in control word, stalls (R4 R5 R11)
        put_desc(32'h1100, 32'hB000_0000, 32'd0,      8'h2F, 8'hA3, 16'hFFEE, 32'h1110);
        put_desc(32'h1110, 32'hB000_4000, 32'h1234,   8'h00, 8'h0C, 16'h1200, 32'h1120);
        put_desc(32'h1120, 32'hB000_8000, 32'd0,      8'hF0, 8'h5F, 16'h00AA, 32'h0);
        walk(32'h1100, 1, 0, 0);

        // last entry with a nonzero link: link ignored (R7)
        put_desc(32'h2000, 32'hC000_0000, 32'd16, 8'h80, 8'h02, 16'h0, 32'h2010);
        put_desc(32'h2010, 32'hC111_0000, 32'd16, 8'h80, 8'h02, 16'h0, 32'h0);
        walk(32'h2000, 0, 0, 0);
        walk(32'h2000, 1, 0, 0);

        // broken chain: zero link on a non-last entry (R8)
        put_desc(32'h3000, 32'hD000_0000, 32'd4, 8'h10, 8'h01, 16'h0, 32'h3010);
        put_desc(32'h3010, 32'hD000_1000, 32'd4, 8'h10, 8'h01, 16'h0, 32'h0);
        walk(32'h3000, 1, 0, 0);

        // broken chain: link only 4-byte aligned (R8)
        put_desc(32'h3100, 32'hD100_0000, 32'd4, 8'h00, 8'h01, 16'h0, 32'h3104);
        walk(32'h3100, 0, 0, 0);

        // bad start addresses (R9)
        walk(32'h0, 0, 0, 0);
        walk(32'h4004, 1, 0, 0);

        // non-contiguous links and a start while busy (R6 R10)
        put_desc(32'h5000, 32'hE000_0000, 32'd1, 8'h20, 8'h03, 16'h0, 32'h6000);
        put_desc(32'h6000, 32'hE000_1000, 32'd2, 8'h10, 8'h03, 16'h0, 32'h5010);
        put_desc(32'h5010, 32'hE000_2000, 32'd3, 8'h80, 8'h03, 16'h0, 32'h0);
        walk(32'h5000, 1, 10, 32'h1000);
        walk(32'h5000, 0, 3, 32'h0);

        finish_run();
    end
endmodule